// File: doc/BRIEF.md
# Two-Event Rendezvous Controller with Strong Restart

This block is a synchronous reactive controller that watches two single-cycle event inputs. The events may come in either order or in the same cycle. When the later of the two shows up, the block raises a one-cycle strobe in that same cycle. It then stays quiet until a restart event re-arms it. A typical use is sequencing a memory write: the restart marks a new request, the two events mark the arrival of the address and the arrival of the data, and the strobe is the write enable.

Internally the behaviour is built from parts rather than listed as a flat product automaton. There is one sticky wait flag for each awaited event, and the flags run side by side. A join term detects when every flag is satisfied. A phase register records whether the block is waiting or halted. Restart acts as a strong abort: in any cycle where it is present, the other two events are discarded. The state grows by one flag for each extra awaited event, not by a doubling of automaton states.

Top module: `abro_ctrl`

## Requirements
- R1: While `rst` is high, and after it falls, the block is waiting with no event remembered. `strobe` is low until both events have been seen.
- R2: If one event was seen in an earlier cycle, `strobe` is high in the same cycle that the other event arrives (combinational path, no added latency).
- R3: If `ev_a` and `ev_b` are both high in one waiting cycle with neither seen before, `strobe` is high in that cycle.
- R4: Once `strobe` has fired, any further `ev_a` or `ev_b` keeps `strobe` low until a cycle in which `restart` is high.
- R5: `restart` during the waiting phase clears any remembered event, so one later event alone does not fire `strobe`.
- R6: `restart` during the halted phase re-arms the block, and the next pair of events fires `strobe` again.
- R7: An `ev_a` or `ev_b` in the same cycle as `restart` is dropped and does not count toward the next round.
- R8: An event that arrives while the other is still awaited is remembered. Repeats of it change nothing, and `strobe` fires exactly once, when the other event arrives.
- R9: `strobe` is a single-cycle pulse and is high at most once between successive `restart` cycles.
- R10: `strobe` is low in every cycle where `restart` is high, whatever `ev_a` and `ev_b` are.
- R11: Under arbitrary mixed stimulus, `strobe` matches a flat four-state reference automaton cycle by cycle. Its states are: none seen, only A seen, only B seen, and done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; puts the block in the waiting phase with no event remembered |
| ev_a | input | 1 | First awaited event, single-cycle |
| ev_b | input | 1 | Second awaited event, single-cycle |
| restart | input | 1 | Strong-abort restart event, single-cycle |
| strobe | output | 1 | One-cycle pulse when both events have been seen |

## Verification
Some properties are checked by assertions on every cycle. These are: strobe never lasts two cycles and never coincides with restart; a halted block stays silent; restart always leaves the waiting phase behind it; a remembered flag persists until it is cleared; and a silenced flag stays clear. The zero-latency timing of the strobe relative to the second event only shows up in the bench's directed scenarios. So do the loss of events that coincide with restart and the re-arming after a halt. Cycle-exact agreement with the flat reference automaton under long random mixes is also shown only by the bench.

// File: rtl/abro_pkg.sv
package abro_pkg;

    // Phase of the top-level sequence: waiting for events or halted after the strobe.
    typedef enum logic [0:0] {
        PH_WAIT = 1'b0,
        PH_HALT = 1'b1
    } phase_e;

    // Control that the abort layer hands down to every wait flag.
    typedef struct packed {
        logic listen;   // events may be latched this cycle
        logic clear;    // flags return to empty at the next edge
    } flag_ctl_t;

    // Events are only heard when no restart is present and the block is not halted.
    function automatic logic listen_gate(input logic restart, input phase_e phase);
        return !restart && (phase == PH_WAIT);
    endfunction

endpackage

// File: rtl/abro_wait_flag.sv
module abro_wait_flag
    import abro_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ev,
    input  flag_ctl_t ctl,
    output logic      met
);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
        end else if (ctl.clear) begin
            seen_q <= 1'b0;
        end else if (ctl.listen && ev) begin
            seen_q <= 1'b1;
        end
    end

    // Satisfied if remembered earlier or present now.
    assign met = seen_q || ev;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !ctl.clear) |=> seen_q);   // R8

    AST_DEAF_FLAG_STAYS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!ctl.listen && !seen_q) |=> !seen_q);   // R7

endmodule

// File: rtl/abro_join.sv
module abro_join #(
    parameter int NUM_EVENTS = 2
) (
    input  logic [NUM_EVENTS-1:0] met,
    output logic                  all_met
);

    assign all_met = &met;

endmodule

// File: rtl/abro_abort_ctl.sv
module abro_abort_ctl
    import abro_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      all_met,
    output flag_ctl_t ctl,
    output logic      fire,
    output logic      halted
);

    phase_e phase_q;
    phase_e phase_d;
    logic   listen;

    assign listen = listen_gate(restart, phase_q);
    assign fire   = listen && all_met;

    always_comb begin
        ctl.listen = listen;
        ctl.clear  = restart || fire;
    end

    always_comb begin
        phase_d = phase_q;
        if (restart) begin
            phase_d = PH_WAIT;
        end else if (fire) begin
            phase_d = PH_HALT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_WAIT;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign halted = (phase_q == PH_HALT);

    AST_REARM_ON_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase_q == PH_WAIT));   // R6

    AST_HALT_AFTER_FIRE: assert property (@(posedge clk) disable iff (rst)
        fire |=> (phase_q == PH_HALT));   // R4

endmodule

// File: rtl/abro_ctrl.sv
module abro_ctrl
    import abro_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ev_a,
    input  logic ev_b,
    input  logic restart,
    output logic strobe
);

    localparam int NUM_EVENTS = 2;

    logic [NUM_EVENTS-1:0] ev_vec;
    logic [NUM_EVENTS-1:0] met_vec;
    logic                  all_met;
    logic                  halted;
    flag_ctl_t             ctl;

    assign ev_vec = {ev_b, ev_a};

    generate
        for (genvar g = 0; g < NUM_EVENTS; g++) begin : g_flag
            abro_wait_flag i_flag (
                .clk (clk),
                .rst (rst),
                .ev  (ev_vec[g]),
                .ctl (ctl),
                .met (met_vec[g])
            );
        end
    endgenerate

    abro_join #(.NUM_EVENTS(NUM_EVENTS)) i_join (
        .met     (met_vec),
        .all_met (all_met)
    );

    abro_abort_ctl i_abort (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .all_met (all_met),
        .ctl     (ctl),
        .fire    (strobe),
        .halted  (halted)
    );

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);   // R9

    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (rst)
        restart |-> !strobe);   // R10

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> !strobe);   // R4

    AST_PAIR_FIRES: assert property (@(posedge clk) disable iff (rst)
        (!halted && !restart && ev_a && ev_b) |-> strobe);   // R3

endmodule

// File: tb/test_abro_ctrl.sv
`timescale 1ns/1ps
module test_abro_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_a = 1'b0;
    logic ev_b = 1'b0;
    logic restart = 1'b0;
    logic strobe;

    int checks = 0;
    int errors = 0;

    // Flat reference automaton: 0 none seen, 1 only A, 2 only B, 3 done.
    int ref_st = 0;

    always #2.5 clk = ~clk;

    abro_ctrl i_abro_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ev_a    (ev_a),
        .ev_b    (ev_b),
        .restart (restart),
        .strobe  (strobe)
    );

    function automatic logic ref_out(int st, logic a, logic b, logic r);
        if (r) return 1'b0;
        case (st)
            0: return a && b;
            1: return b;
            2: return a;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int ref_next(int st, logic a, logic b, logic r);
        if (r) return 0;
        case (st)
            0: return (a && b) ? 3 : (a ? 1 : (b ? 2 : 0));
            1: return b ? 3 : 1;
            2: return a ? 3 : 2;
            default: return 3;
        endcase
    endfunction

    task automatic check(logic got, logic exp, string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s strobe actual %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, sample the combinational strobe before the next rising edge.
    task automatic step(logic a, logic b, logic r, logic exp, string tag);
        @(negedge clk);
        ev_a = a; ev_b = b; restart = r;
        #1;
        check(strobe, exp, tag);
        ref_st = ref_next(ref_st, a, b, r);
    endtask

    task automatic hard_reset();
        @(negedge clk);
        rst = 1'b1; ev_a = 1'b0; ev_b = 1'b0; restart = 1'b0;
        @(negedge clk);
        #1;
        check(strobe, 1'b0, "R1");
        @(negedge clk);
        rst = 1'b0;
        ref_st = 0;
    endtask

    task automatic t_reset_state();
        hard_reset();
        step(0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, "R1");
        step(0, 1, 0, 1, "R1");
    endtask

    task automatic t_order();
        step(0, 0, 1, 0, "R6");
        step(1, 0, 0, 0, "R2");
        step(0, 0, 0, 0, "R2");
        step(0, 1, 0, 1, "R2");
        step(0, 0, 1, 0, "R6");
        step(0, 1, 0, 0, "R2");
        step(1, 0, 0, 1, "R2");
    endtask

    task automatic t_together();
        step(0, 0, 1, 0, "R6");
        step(1, 1, 0, 1, "R3");
        step(0, 0, 0, 0, "R9");
    endtask

    task automatic t_halt_then_rearm();
        step(0, 0, 1, 0, "R6");
        step(1, 1, 0, 1, "R3");
        step(1, 0, 0, 0, "R4");
        step(0, 1, 0, 0, "R4");
        step(1, 1, 0, 0, "R4");
        step(0, 0, 1, 0, "R6");
        step(1, 1, 0, 1, "R6");
    endtask

    task automatic t_abort_while_waiting();
        step(0, 0, 1, 0, "R5");
        step(1, 0, 0, 0, "R5");
        step(0, 0, 1, 0, "R5");
        step(0, 1, 0, 0, "R5");
        step(1, 0, 0, 1, "R5");
    endtask

    task automatic t_drop_with_restart();
        step(0, 0, 1, 0, "R7");
        step(1, 0, 1, 0, "R7");
        step(0, 1, 0, 0, "R7");
        step(1, 0, 0, 1, "R7");
        step(0, 1, 1, 0, "R7");
        step(1, 0, 0, 0, "R7");
        step(0, 1, 0, 1, "R7");
    endtask

    task automatic t_abort_with_both();
        step(1, 1, 1, 0, "R10");
        step(0, 0, 0, 0, "R10");
        step(1, 0, 0, 0, "R10");
        step(0, 1, 0, 1, "R10");
    endtask

    task automatic t_repeats();
        step(0, 0, 1, 0, "R8");
        step(1, 0, 0, 0, "R8");
        step(1, 0, 0, 0, "R8");
        step(1, 0, 0, 0, "R8");
        step(0, 1, 0, 1, "R8");
        step(0, 1, 0, 0, "R9");
        step(1, 1, 0, 0, "R9");
    endtask

    task automatic t_random_vs_reference();
        step(0, 0, 1, 0, "R11");
        for (int i = 0; i < 3000; i++) begin
            logic a, b, r;
            a = ($urandom_range(0, 2) == 0);
            b = ($urandom_range(0, 2) == 0);
            r = ($urandom_range(0, 7) == 0);
            step(a, b, r, ref_out(ref_st, a, b, r), "R11");
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired, run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_order();
        t_together();
        t_halt_then_rearm();
        t_abort_while_waiting();
        t_drop_with_restart();
        t_abort_with_both();
        t_repeats();
        t_random_vs_reference();
        hard_reset();
        step(1, 1, 0, 1, "R1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule